// File: doc/BRIEF.md
# Variable-Length Instruction Framer

The framer sits behind a byte-wide instruction fetch stream in which instructions of 2, 3, 8 or 16 bytes are packed back to back with no separators. It walks the stream one byte per cycle, finds where each instruction ends, and hands downstream logic one record per instruction: the byte offset where it starts, its length in bytes and a class code. Downstream decode logic can then pull whole instructions out of a buffer without length logic of its own.

Length is settled in two steps. The low nibble of an instruction's first byte selects a size directly for fifteen of its sixteen values. The remaining value defers the choice to the low nibble of the instruction's fourth byte, which selects 8 or 16 bytes or flags the encoding as illegal. No boundary is committed for such an instruction until that fourth byte has been seen. An illegal encoding raises a one-cycle error carrying the start offset, and framing restarts one byte after that start, re-examining the three bytes already taken before any new input is accepted.

Top module: `vlf_framer`

## Requirements
- R1: After a synchronous active-high reset no record and no error is presented, in_ready is high, and the next accepted byte begins an instruction at offset 0.
- R2: For the first-byte low nibble op = byte0[3:0] (bits [7:4] ignored): op 0..7 gives a 3-byte record with class 1, op 8..13 a 2-byte record with class 0, op 14 a 16-byte record with class 2.
- R3: For op 15 the length comes from s = byte3[3:0] of that instruction: s[0] = 0 gives 8 bytes with class 4; s[0] = 1 gives 16 bytes with class 5, except the illegal values of R4.
- R4: For op 15 with s equal to 4'hD or 4'hF no record is produced; err_valid is high for exactly one cycle with err_off equal to the instruction's start offset, and framing resumes at start offset + 1, reprocessing the bytes at start+1..start+3 before any new byte.
- R5: Records appear in stream order with rec_off equal to the start offset of the instruction; each instruction starts at the byte after the previous record's last byte, or after an error restart.
- R6: A record is presented only after the last byte of its instruction has been accepted.
- R7: While rec_valid is high and rec_ready is low the record stays valid and unchanged, and no record is lost.
- R8: Cycles with in_valid low, whatever in_data carries, do not change the sequence of records or errors; no accepted byte is dropped.
- R9: While re-examined bytes are pending after an error, in_ready is low; in particular in_ready is low in the cycle err_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Framer accepts the byte this cycle |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Downstream accepts the record |
| rec_off | output | OFF_W | Start offset of the instruction |
| rec_len | output | 5 | Instruction length in bytes |
| rec_cls | output | 3 | Length class code |
| err_valid | output | 1 | One-cycle illegal-encoding flag |
| err_off | output | OFF_W | Start offset of the illegal instruction |

## Verification
Every cycle the assertions hold the record steady under back-pressure, keep each presented length within the four legal sizes and paired with its class code, and keep the error flag to a single cycle during which input is closed. Only the bench's scenarios can show that the offsets and sizes form the right sequence: that the deferred fourth-byte split picks the right width, that bytes after an illegal start are re-read in order, and that bubbles and stalls leave the framing untouched. The bench sweeps every first-nibble and fourth-byte-nibble pair, each after a reset, and then long random streams under several rate mixes.

// File: rtl/vlf_pkg.sv
package vlf_pkg;

    localparam int LEN_W     = 5;
    localparam int CLS_W     = 3;
    localparam int OPC_W     = 4;
    localparam int BYTE_W    = 8;
    // position, within an instruction, of the byte that settles a deferred size
    localparam int SPLIT_IDX = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_N2   = 3'd0,
        CLS_N3   = 3'd1,
        CLS_W16  = 3'd2,
        CLS_PEND = 3'd3,
        CLS_X8   = 3'd4,
        CLS_X16  = 3'd5,
        CLS_BAD  = 3'd6
    } vlf_cls_e;

    typedef struct packed {
        vlf_cls_e           cls;
        logic [LEN_W-1:0]   len;
    } vlf_len_t;

    // first step: size from the opcode nibble of the leading byte
    function automatic vlf_len_t head_lookup(input logic [OPC_W-1:0] op);
        vlf_len_t r;
        if (op <= 4'd7) begin
            r.cls = CLS_N3;  r.len = LEN_W'(3);
        end else if (op <= 4'd13) begin
            r.cls = CLS_N2;  r.len = LEN_W'(2);
        end else if (op == 4'd14) begin
            r.cls = CLS_W16; r.len = LEN_W'(16);
        end else begin
            r.cls = CLS_PEND; r.len = '0;
        end
        return r;
    endfunction

    // second step: size from the selector nibble of the deferred byte
    function automatic vlf_len_t tail_lookup(input logic [OPC_W-1:0] sel);
        vlf_len_t r;
        if (sel == 4'hD || sel == 4'hF) begin
            r.cls = CLS_BAD; r.len = '0;
        end else if (sel[0]) begin
            r.cls = CLS_X16; r.len = LEN_W'(16);
        end else begin
            r.cls = CLS_X8;  r.len = LEN_W'(8);
        end
        return r;
    endfunction

endpackage

// File: rtl/vlf_classify.sv
module vlf_classify
    import vlf_pkg::*;
(
    input  logic [OPC_W-1:0] head_op,
    input  logic [OPC_W-1:0] tail_sel,
    output vlf_len_t         head,
    output vlf_len_t         tail
);

    localparam int N_ENT = 1 << OPC_W;

    vlf_len_t head_lut [N_ENT];
    vlf_len_t tail_lut [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_lut
        assign head_lut[g] = head_lookup(OPC_W'(g));
        assign tail_lut[g] = tail_lookup(OPC_W'(g));
    end

    assign head = head_lut[head_op];
    assign tail = tail_lut[tail_sel];

endmodule

// File: rtl/vlf_byte_src.sv
module vlf_byte_src #(
    parameter int DEPTH  = 3,
    parameter int BYTE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [BYTE_W-1:0]             in_data,
    input  logic                          take,
    input  logic                          load,
    input  logic [DEPTH-1:0][BYTE_W-1:0]  load_bytes,
    output logic                          src_valid,
    output logic [BYTE_W-1:0]             src_data,
    output logic                          busy
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] buf_b;
        logic [CNT_W-1:0]             cnt;
    } rp_t;

    rp_t rp_q, rp_d;

    always_comb begin
        busy      = (rp_q.cnt != '0);
        src_valid = busy | in_valid;
        src_data  = busy ? rp_q.buf_b[0] : in_data;

        rp_d = rp_q;
        if (load) begin
            rp_d.buf_b = load_bytes;
            rp_d.cnt   = CNT_W'(DEPTH);
        end else if (take && busy) begin
            for (int k = 0; k < DEPTH; k++) begin
                rp_d.buf_b[k] = (k < DEPTH - 1) ? rp_q.buf_b[k+1] : '0;
            end
            rp_d.cnt = rp_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rp_q <= '0;
        else     rp_q <= rp_d;
    end

    AST_RP_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy); // R4

    AST_RP_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (busy && take && !load) |=> (rp_q.cnt == $past(rp_q.cnt) - CNT_W'(1))); // R9

endmodule

// File: rtl/vlf_out_slot.sv
module vlf_out_slot #(
    parameter int OFF_W = 16,
    parameter int LEN_W = 5,
    parameter int CLS_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [OFF_W-1:0]  ld_off,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic [CLS_W-1:0]  ld_cls,
    input  logic              rec_ready,
    output logic              rec_valid,
    output logic [OFF_W-1:0]  rec_off,
    output logic [LEN_W-1:0]  rec_len,
    output logic [CLS_W-1:0]  rec_cls,
    output logic              go
);

    typedef struct packed {
        logic              v;
        logic [OFF_W-1:0]  off;
        logic [LEN_W-1:0]  len;
        logic [CLS_W-1:0]  cls;
    } slot_t;

    slot_t sl_q, sl_d;

    always_comb begin
        go   = !sl_q.v || rec_ready;
        sl_d = sl_q;
        if (go) begin
            sl_d.v = load;
            if (load) begin
                sl_d.off = ld_off;
                sl_d.len = ld_len;
                sl_d.cls = ld_cls;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sl_q <= '0;
        else     sl_q <= sl_d;
    end

    assign rec_valid = sl_q.v;
    assign rec_off   = sl_q.off;
    assign rec_len   = sl_q.len;
    assign rec_cls   = sl_q.cls;

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sl_q.v && !rec_ready) |=> (sl_q.v && $stable(sl_q.off) && $stable(sl_q.len)
                                    && $stable(sl_q.cls))); // R7

    AST_LOAD_FREE: assert property (@(posedge clk) disable iff (rst)
        load |-> go); // R7

endmodule

// File: rtl/vlf_framer.sv
module vlf_framer
    import vlf_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [OFF_W-1:0]  rec_off,
    output logic [4:0]        rec_len,
    output logic [2:0]        rec_cls,
    output logic              err_valid,
    output logic [OFF_W-1:0]  err_off
);

    localparam int CAP_N = SPLIT_IDX - 1;
    localparam int RP_D  = SPLIT_IDX;

    typedef struct packed {
        logic [LEN_W-1:0]             idx;
        logic [LEN_W-1:0]             tgt;
        vlf_cls_e                     cls;
        logic [OFF_W-1:0]             start;
        logic [OFF_W-1:0]             cur_off;
        logic [CAP_N-1:0][BYTE_W-1:0] cap;
        logic                         err_v;
        logic [OFF_W-1:0]             err_off;
    } core_t;

    core_t cq, cd;

    logic                          src_valid;
    logic [BYTE_W-1:0]             src_data;
    logic                          rp_busy;
    logic                          go;
    logic                          take;
    logic                          rp_load;
    logic [RP_D-1:0][BYTE_W-1:0]   rp_bytes;
    logic                          emit;
    logic [OFF_W-1:0]              emit_off;
    logic [LEN_W-1:0]              emit_len;
    vlf_cls_e                      emit_cls;
    vlf_cls_e                      cls_now;
    logic [LEN_W-1:0]              tgt_now;
    vlf_len_t                      head;
    vlf_len_t                      tail;

    vlf_classify u_cls (
        .head_op  (src_data[OPC_W-1:0]),
        .tail_sel (src_data[OPC_W-1:0]),
        .head     (head),
        .tail     (tail)
    );

    vlf_byte_src #(.DEPTH(RP_D), .BYTE_W(BYTE_W)) u_src (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .take       (take),
        .load       (rp_load),
        .load_bytes (rp_bytes),
        .src_valid  (src_valid),
        .src_data   (src_data),
        .busy       (rp_busy)
    );

    vlf_out_slot #(.OFF_W(OFF_W), .LEN_W(LEN_W), .CLS_W(CLS_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (emit),
        .ld_off    (emit_off),
        .ld_len    (emit_len),
        .ld_cls    (emit_cls),
        .rec_ready (rec_ready),
        .rec_valid (rec_valid),
        .rec_off   (rec_off),
        .rec_len   (rec_len),
        .rec_cls   (rec_cls),
        .go        (go)
    );

    assign take     = src_valid && go;
    assign in_ready = !rp_busy && go;

    always_comb begin
        cd        = cq;
        cd.err_v  = 1'b0;
        emit      = 1'b0;
        rp_load   = 1'b0;
        rp_bytes  = {src_data, cq.cap};
        cls_now   = cq.cls;
        tgt_now   = cq.tgt;
        emit_off  = cq.start;
        emit_len  = cq.tgt;
        emit_cls  = cq.cls;

        if (take) begin
            cd.cur_off = cq.cur_off + OFF_W'(1);
            if (cq.idx == '0) begin
                cd.start = cq.cur_off;
                cd.cls   = head.cls;
                cd.tgt   = head.len;
                cd.idx   = LEN_W'(1);
            end else begin
                for (int k = 0; k < CAP_N; k++) begin
                    if (cq.idx == LEN_W'(k + 1)) cd.cap[k] = src_data;
                end
                if (cq.cls == CLS_PEND && cq.idx == LEN_W'(SPLIT_IDX)) begin
                    cls_now = tail.cls;
                    tgt_now = tail.len;
                end
                if (cls_now == CLS_BAD) begin
                    cd.err_v   = 1'b1;
                    cd.err_off = cq.start;
                    cd.cur_off = cq.start + OFF_W'(1);
                    cd.idx     = '0;
                    rp_load    = 1'b1;
                end else if (cq.idx + LEN_W'(1) == tgt_now) begin
                    emit     = 1'b1;
                    emit_len = tgt_now;
                    emit_cls = cls_now;
                    cd.idx   = '0;
                end else begin
                    cd.idx = cq.idx + LEN_W'(1);
                    cd.cls = cls_now;
                    cd.tgt = tgt_now;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cq <= '0;
        else     cq <= cd;
    end

    assign err_valid = cq.err_v;
    assign err_off   = cq.err_off;

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid); // R4

    AST_ERR_INPUT_CLOSED: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> !in_ready); // R9

    AST_REC_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_len == 5'd2 || rec_len == 5'd3 || rec_len == 5'd8
                       || rec_len == 5'd16)); // R2

    AST_REC_CLASS_PAIR: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> ((rec_cls == 3'd0 && rec_len == 5'd2)
                    || (rec_cls == 3'd1 && rec_len == 5'd3)
                    || (rec_cls == 3'd2 && rec_len == 5'd16)
                    || (rec_cls == 3'd4 && rec_len == 5'd8)
                    || (rec_cls == 3'd5 && rec_len == 5'd16))); // R3

    AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |-> !in_ready); // R7

endmodule

// File: tb/vlf_framer_tb.sv
module vlf_framer_tb;

    localparam int OFF_W = 16;
    localparam int MAXB  = 4096;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             rec_ready = 1'b0;
    logic             in_ready;
    logic             rec_valid;
    logic [OFF_W-1:0] rec_off;
    logic [4:0]       rec_len;
    logic [2:0]       rec_cls;
    logic             err_valid;
    logic [OFF_W-1:0] err_off;

    vlf_framer #(.OFF_W(OFF_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .rec_valid (rec_valid),
        .rec_ready (rec_ready),
        .rec_off   (rec_off),
        .rec_len   (rec_len),
        .rec_cls   (rec_cls),
        .err_valid (err_valid),
        .err_off   (err_off)
    );

    always #10 clk = ~clk;   // 50 MHz

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc   = 0;
    bit  dead  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] stream [MAXB];
    int n_bytes;
    int e_off [MAXB];
    int e_len [MAXB];
    int e_cls [MAXB];
    int n_exp;
    int x_off [MAXB];
    int n_xerr;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected records and errors, walked from the requirements
    task automatic build_model();
        int p;
        p = 0;
        n_exp  = 0;
        n_xerr = 0;
        while (p < n_bytes) begin
            int op;
            int len;
            int cls;
            int sel;
            op = int'(stream[p][3:0]);
            if (op < 8) begin
                len = 3; cls = 1;
            end else if (op < 14) begin
                len = 2; cls = 0;
            end else if (op == 14) begin
                len = 16; cls = 2;
            end else begin
                if (p + 3 >= n_bytes) break;
                sel = int'(stream[p+3][3:0]);
                if (sel == 13 || sel == 15) begin
                    x_off[n_xerr] = p;
                    n_xerr++;
                    p++;
                    continue;
                end
                if (sel % 2 == 1) begin len = 16; cls = 5; end
                else              begin len = 8;  cls = 4; end
            end
            if (p + len > n_bytes) break;
            e_off[n_exp] = p;
            e_len[n_exp] = len;
            e_cls[n_exp] = cls;
            n_exp++;
            p += len;
        end
    endtask

    task automatic run_scen(input int vpct, input int rpct);
        int  idx;
        int  rcnt;
        int  ecnt;
        int  drain;
        bit  hold;
        int  h_off;
        int  h_len;
        int  h_cls;
        string tag;
        idx = 0; rcnt = 0; ecnt = 0; drain = 0; hold = 1'b0;
        h_off = 0; h_len = 0; h_cls = 0;
        build_model();

        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; rec_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!rec_valid, "R1", "rec_valid after reset", int'(rec_valid), 0);
        chk(!err_valid, "R1", "err_valid after reset", int'(err_valid), 0);
        chk(in_ready,   "R1", "in_ready after reset",  int'(in_ready), 1);

        while (!dead) begin
            @(negedge clk);
            if (cyc > 180000) begin
                dead = 1'b1;
                chk(1'b0, "WD", "watchdog expired", cyc, 0);
                break;
            end
            rec_ready = (idx >= n_bytes) ? 1'b1 : ($urandom_range(99) < rpct);
            in_valid  = (idx < n_bytes) && ($urandom_range(99) < vpct);
            in_data   = in_valid ? stream[idx] : 8'($urandom);   // R8 garbage in bubbles
            #1;
            if (hold) begin
                chk(rec_valid && int'(rec_off) == h_off && int'(rec_len) == h_len
                    && int'(rec_cls) == h_cls, "R7", "record held under stall",
                    int'(rec_off), h_off);
                hold = 1'b0;
            end
            if (rec_valid && !rec_ready) begin
                hold  = 1'b1;
                h_off = int'(rec_off);
                h_len = int'(rec_len);
                h_cls = int'(rec_cls);
            end
            if (rec_valid && rec_ready) begin
                if (rcnt >= n_exp) begin
                    chk(1'b0, "R5", "unexpected record offset", int'(rec_off), -1);
                end else begin
                    tag = (e_cls[rcnt] >= 4) ? "R3" : "R2";
                    chk(int'(rec_off) == e_off[rcnt], "R5", "record offset",
                        int'(rec_off), e_off[rcnt]);
                    chk(int'(rec_len) == e_len[rcnt], tag, "record length",
                        int'(rec_len), e_len[rcnt]);
                    chk(int'(rec_cls) == e_cls[rcnt], tag, "record class",
                        int'(rec_cls), e_cls[rcnt]);
                    chk(int'(rec_off) + int'(rec_len) <= idx, "R6",
                        "record end vs bytes accepted", int'(rec_off) + int'(rec_len), idx);
                end
                rcnt++;
            end
            if (err_valid) begin
                chk(!in_ready, "R9", "in_ready during error", int'(in_ready), 0);
                if (ecnt < n_xerr)
                    chk(int'(err_off) == x_off[ecnt], "R4", "error offset",
                        int'(err_off), x_off[ecnt]);
                else
                    chk(1'b0, "R4", "unexpected error offset", int'(err_off), -1);
                ecnt++;
            end
            if (in_valid && in_ready) idx++;
            if (idx >= n_bytes) drain++;
            if (drain > 40) break;
        end
        chk(rcnt == n_exp,  "R8", "record count", rcnt, n_exp);
        chk(ecnt == n_xerr, "R4", "error count",  ecnt, n_xerr);
    endtask

    initial begin
        // sweep: every opcode nibble against every deferred-byte nibble
        for (int op = 0; op < 16 && !dead; op++) begin
            for (int sel = 0; sel < 16 && !dead; sel++) begin
                int len;
                int mix;
                if (op < 8)        len = 3;
                else if (op < 14)  len = 2;
                else if (op == 14) len = 16;
                else if (sel == 13 || sel == 15) len = 4;
                else if (sel % 2 == 1) len = 16;
                else len = 8;
                stream[0] = {4'(sel), 4'(op)};
                for (int k = 1; k < len; k++)
                    stream[k] = (k == 3) ? {4'(op), 4'(sel)} : 8'($urandom);
                for (int k = len; k < len + 10; k++)
                    stream[k] = 8'($urandom);
                n_bytes = len + 10;
                mix = (op * 16 + sel) % 3;
                if (mix == 0)      run_scen(100, 100);
                else if (mix == 1) run_scen(70, 60);
                else               run_scen(40, 30);
            end
        end
        // long random streams under different rate mixes
        for (int s = 0; s < 3 && !dead; s++) begin
            n_bytes = 1500;
            for (int k = 0; k < n_bytes; k++) stream[k] = 8'($urandom);
            if (s == 0)      run_scen(100, 100);
            else if (s == 1) run_scen(65, 45);
            else             run_scen(35, 85);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule